// File: doc/BRIEF.md
# Open-Row Aware Memory Command Arbiter

This block holds a small queue of pending memory reads and writes posted by several bus masters and, each cycle the downstream command sequencer can accept one, names the queue slot to issue next. Each entry carries its direction, the priority of the master that posted it, and its target bank and row. The sequencer supplies the open/closed state and open row of every bank, a flag saying the read-return buffer is full, and a programmable aging threshold.

Selection works in stages. Reads and writes are ranked separately. Within each direction, entries that hit an already open row are preferred. Among the remaining candidates the highest effective priority wins, and a tie goes to the oldest entry. The read candidate is then issued ahead of the write candidate unless the read-return buffer is full. To keep a low-priority master from starving, every entry counts the transfers granted while it waits. Once that count reaches the threshold, the entry ranks above every normal priority. A threshold of 0xFE is the recommended setting.

A two-state controller tracks occupancy. In `ST_EMPTY` no slot holds a command and nothing is granted. In `ST_SERVE` at least one slot is occupied and grants may be issued. The transition `EMPTY->SERVE` is taken on any edge that leaves a slot occupied. The transition `SERVE->EMPTY` is taken on an edge that leaves every slot free. `SERVE->SERVE` covers all other cases.

Top module: `cmdarb_top`

## Requirements
- R1: After reset all slots are free, the state is ST_EMPTY, grant_vld is 0 and enq_rdy is 1.
- R2: An accepted command (enq_vld with enq_rdy high) is written into the lowest-numbered free slot. When all 8 slots are occupied, enq_rdy is 0 and an offered command is dropped without changing the queue.
- R3: An entry hits when bank_open[bank] is 1 and the bank's open row (open_rows bits bank*13 +: 13) equals the entry's row. Within one direction, if any entry hits, only hitting entries are candidates; otherwise every entry of that direction is a candidate.
- R4: Among candidates the larger enq_prio value (3 bits, 7 highest) wins. On equal priority the entry that has waited more cycles since enqueue wins.
- R5: If a read candidate exists and rd_fifo_full is 0, the read is granted (grant_write=0). Otherwise a write candidate is granted if one exists. No read is granted while rd_fifo_full is 1.
- R6: Each entry's wait count is cleared on enqueue and incremented on every grant of another entry. When the count is at least old_count, the entry outranks all non-aged entries, and aged entries are ordered by age.
- R7: A grant (grant_vld=1) occurs only while issue_rdy is 1. The granted slot is free after that clock edge, and the other entries keep their age and wait counts.
- R8: When a grant and an enqueue share a clock edge, the new command goes into the lowest slot that was free before that edge, and its wait count starts at 0 and is not incremented by that grant.
- R9: The state is ST_SERVE exactly when some slot is occupied. A command accepted on one edge can be granted in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_vld | input | 1 | New command offered |
| enq_write | input | 1 | 1 = write, 0 = read |
| enq_prio | input | 3 | Master priority, 7 highest |
| enq_bank | input | 3 | Target bank |
| enq_row | input | 13 | Target row |
| enq_rdy | output | 1 | A slot is free |
| bank_open | input | 8 | Per-bank open flag |
| open_rows | input | 104 | Open row per bank, 13 bits each, bank 0 lowest |
| rd_fifo_full | input | 1 | Read-return buffer full |
| old_count | input | 8 | Aging threshold in granted transfers |
| issue_rdy | input | 1 | Sequencer accepts a command this cycle |
| grant_vld | output | 1 | A slot is granted this cycle |
| grant_slot | output | 3 | Granted slot index |
| grant_write | output | 1 | Direction of the granted command |

## Verification
The case of interest is a grant and an enqueue on the same clock edge. The slot being released must not be reused at that edge, and the newcomer's wait count must not absorb the grant that happened alongside it. The bench provokes this by raising issue_rdy and enq_vld together while one entry is queued. It then confirms that the new command appears in slot 1 rather than slot 0. Finally, it uses a threshold of 1 against a later higher-priority entry to show that the newcomer was not aged by that grant.

// File: rtl/cmdarb_pkg.sv
package cmdarb_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_SERVE = 1'b1
    } arb_state_e;
endpackage

// File: rtl/cmdarb_pick.sv
// Ranks one direction: open-row hits first, then the largest key, lowest index on a tie.
module cmdarb_pick #(
    parameter int NSLOT = 8,
    parameter int KEY_W = 10,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0]            elig,
    input  logic [NSLOT-1:0]            hit,
    input  logic [NSLOT-1:0][KEY_W-1:0] key,
    output logic                        found,
    output logic [SLOT_W-1:0]           idx
);
    logic [NSLOT-1:0] mask;
    logic [KEY_W-1:0] best;

    always_comb begin
        mask  = (|(elig & hit)) ? (elig & hit) : elig;
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (mask[i] && (!found || key[i] > best)) begin
                found = 1'b1;
                best  = key[i];
                idx   = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/cmdarb_slots.sv
// Slot storage with per-slot age (cycles waited) and wait (transfers granted meanwhile).
module cmdarb_slots #(
    parameter int NSLOT  = 8,
    parameter int PRIO_W = 3,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 13,
    parameter int AGE_W  = 6,
    parameter int WAIT_W = 8,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enq_take,
    input  logic [SLOT_W-1:0]            enq_idx,
    input  logic                         enq_write,
    input  logic [PRIO_W-1:0]            enq_prio,
    input  logic [BANK_W-1:0]            enq_bank,
    input  logic [ROW_W-1:0]             enq_row,
    input  logic                         grant_take,
    input  logic [SLOT_W-1:0]            grant_idx,
    output logic [NSLOT-1:0]             occ,
    output logic [NSLOT-1:0]             is_wr,
    output logic [NSLOT-1:0][PRIO_W-1:0] prio,
    output logic [NSLOT-1:0][BANK_W-1:0] bank,
    output logic [NSLOT-1:0][ROW_W-1:0]  row,
    output logic [NSLOT-1:0][AGE_W-1:0]  age,
    output logic [NSLOT-1:0][WAIT_W-1:0] waitc
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic load, drop;
        assign load = enq_take && (enq_idx == SLOT_W'(g));
        assign drop = grant_take && (grant_idx == SLOT_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ[g]   <= 1'b0;
                is_wr[g] <= 1'b0;
                prio[g]  <= '0;
                bank[g]  <= '0;
                row[g]   <= '0;
                age[g]   <= '0;
                waitc[g] <= '0;
            end else if (load) begin
                occ[g]   <= 1'b1;
                is_wr[g] <= enq_write;
                prio[g]  <= enq_prio;
                bank[g]  <= enq_bank;
                row[g]   <= enq_row;
                age[g]   <= '0;
                waitc[g] <= '0;
            end else if (drop) begin
                occ[g]   <= 1'b0;
            end else if (occ[g]) begin
                if (age[g] != '1)
                    age[g] <= age[g] + 1'b1;
                if (grant_take && waitc[g] != '1)
                    waitc[g] <= waitc[g] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmdarb_top.sv
module cmdarb_top
    import cmdarb_pkg::*;
#(
    parameter int NSLOT  = 8,
    parameter int NBANK  = 8,
    parameter int PRIO_W = 3,
    parameter int ROW_W  = 13,
    parameter int AGE_W  = 6,
    parameter int WAIT_W = 8,
    localparam int SLOT_W = $clog2(NSLOT),
    localparam int BANK_W = $clog2(NBANK),
    localparam int KEY_W  = 1 + PRIO_W + AGE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enq_vld,
    input  logic                     enq_write,
    input  logic [PRIO_W-1:0]        enq_prio,
    input  logic [BANK_W-1:0]        enq_bank,
    input  logic [ROW_W-1:0]         enq_row,
    output logic                     enq_rdy,
    input  logic [NBANK-1:0]         bank_open,
    input  logic [NBANK*ROW_W-1:0]   open_rows,
    input  logic                     rd_fifo_full,
    input  logic [WAIT_W-1:0]        old_count,
    input  logic                     issue_rdy,
    output logic                     grant_vld,
    output logic [SLOT_W-1:0]        grant_slot,
    output logic                     grant_write
);
    arb_state_e state_q, state_d;

    logic [NSLOT-1:0]             occ, is_wr, hit;
    logic [NSLOT-1:0][PRIO_W-1:0] prio;
    logic [NSLOT-1:0][BANK_W-1:0] bank;
    logic [NSLOT-1:0][ROW_W-1:0]  row;
    logic [NSLOT-1:0][AGE_W-1:0]  age;
    logic [NSLOT-1:0][WAIT_W-1:0] waitc;
    logic [NSLOT-1:0][KEY_W-1:0]  key;
    logic [SLOT_W-1:0]            free_idx, rd_idx, wr_idx;
    logic                         enq_take, rd_found, wr_found;
    logic [NSLOT-1:0]             occ_next;

    // lowest free slot
    always_comb begin
        free_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--)
            if (!occ[i]) free_idx = SLOT_W'(i);
    end
    assign enq_rdy  = ~&occ;
    assign enq_take = enq_vld && enq_rdy;

    cmdarb_slots #(
        .NSLOT(NSLOT), .PRIO_W(PRIO_W), .BANK_W(BANK_W),
        .ROW_W(ROW_W), .AGE_W(AGE_W), .WAIT_W(WAIT_W)
    ) u_slots (
        .clk(clk), .rst_n(rst_n),
        .enq_take(enq_take), .enq_idx(free_idx), .enq_write(enq_write),
        .enq_prio(enq_prio), .enq_bank(enq_bank), .enq_row(enq_row),
        .grant_take(grant_vld), .grant_idx(grant_slot),
        .occ(occ), .is_wr(is_wr), .prio(prio), .bank(bank),
        .row(row), .age(age), .waitc(waitc)
    );

    // open-row hit and ranking key per slot
    for (genvar g = 0; g < NSLOT; g++) begin : g_key
        logic aged;
        assign aged   = waitc[g] >= old_count;
        assign hit[g] = bank_open[bank[g]] &&
                        (open_rows[int'(bank[g])*ROW_W +: ROW_W] == row[g]);
        assign key[g] = aged ? {1'b1, {PRIO_W{1'b1}}, age[g]}
                             : {1'b0, prio[g], age[g]};
    end

    cmdarb_pick #(.NSLOT(NSLOT), .KEY_W(KEY_W)) u_pick_rd (
        .elig(occ & ~is_wr), .hit(hit), .key(key), .found(rd_found), .idx(rd_idx)
    );
    cmdarb_pick #(.NSLOT(NSLOT), .KEY_W(KEY_W)) u_pick_wr (
        .elig(occ & is_wr), .hit(hit), .key(key), .found(wr_found), .idx(wr_idx)
    );

    // occupancy after this edge drives the next state
    always_comb begin
        occ_next = occ;
        if (grant_vld) occ_next[grant_slot] = 1'b0;
        if (enq_take)  occ_next[free_idx]   = 1'b1;
        state_d = (|occ_next) ? ST_SERVE : ST_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        grant_vld   = 1'b0;
        grant_slot  = '0;
        grant_write = 1'b0;
        unique case (state_q)
            ST_EMPTY: ;
            ST_SERVE: begin
                if (rd_found && !rd_fifo_full) begin
                    grant_vld  = issue_rdy;
                    grant_slot = rd_idx;
                end else if (wr_found) begin
                    grant_vld   = issue_rdy;
                    grant_slot  = wr_idx;
                    grant_write = 1'b1;
                end
            end
            default: ;
        endcase
    end

    a_r7_grant_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_rdy |-> !grant_vld);
    a_r7_grant_hits_occupied: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> occ[grant_slot]);
    a_r7_granted_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |=> !occ[$past(grant_slot)]);
    a_r5_no_read_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && rd_fifo_full) |-> grant_write);
    a_r2_full_drops_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (!enq_rdy && !grant_vld) |=> $stable(occ));
    a_r9_state_tracks_occ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVE) == (|occ));
endmodule

// File: tb/cmdarb_top_bench.sv
`timescale 1ns/100ps
module cmdarb_top_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         enq_vld, enq_write;
    logic [2:0]   enq_prio, enq_bank;
    logic [12:0]  enq_row;
    logic         enq_rdy;
    logic [7:0]   bank_open;
    logic [103:0] open_rows;
    logic         rd_fifo_full;
    logic [7:0]   old_count;
    logic         issue_rdy;
    logic         grant_vld, grant_write;
    logic [2:0]   grant_slot;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cmdarb_top u_cmdarb_top (
        .clk(clk), .rst_n(rst_n), .enq_vld(enq_vld), .enq_write(enq_write),
        .enq_prio(enq_prio), .enq_bank(enq_bank), .enq_row(enq_row),
        .enq_rdy(enq_rdy), .bank_open(bank_open), .open_rows(open_rows),
        .rd_fifo_full(rd_fifo_full), .old_count(old_count), .issue_rdy(issue_rdy),
        .grant_vld(grant_vld), .grant_slot(grant_slot), .grant_write(grant_write)
    );

    // fill table: {write, prio}; slot i gets entry i; expected grant order below
    localparam logic [3:0] FILL_WP [8] = '{4'b0010, 4'b1101, 4'b0101, 4'b0010,
                                           4'b1001, 4'b0111, 4'b1101, 4'b0010};
    localparam int EXP_ORD [8] = '{5, 2, 0, 3, 7, 1, 6, 4};

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic enq(input logic w, input logic [2:0] p, input logic [2:0] b,
                       input logic [12:0] r);
        @(negedge clk);
        enq_vld = 1'b1; enq_write = w; enq_prio = p; enq_bank = b; enq_row = r;
        @(negedge clk);
        enq_vld = 1'b0;
    endtask

    // one cycle with issue_rdy high: check the grant that commits at the next edge
    task automatic take(input logic ev, input int es, input logic ew, input string tag);
        @(negedge clk);
        issue_rdy = 1'b1;
        #1;
        check(grant_vld == ev, {tag, " vld"}, int'(grant_vld), int'(ev));
        if (ev) begin
            check(grant_slot == 3'(es), {tag, " slot"}, int'(grant_slot), es);
            check(grant_write == ew, {tag, " dir"}, int'(grant_write), int'(ew));
        end
        @(negedge clk);
        issue_rdy = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; enq_vld = 0; enq_write = 0; enq_prio = 0; enq_bank = 0;
        enq_row = 0; bank_open = 0; open_rows = '0; rd_fifo_full = 0;
        old_count = 8'hFE; issue_rdy = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check(grant_vld == 1'b0, "R1 grant_vld", int'(grant_vld), 0);
        check(enq_rdy == 1'b1, "R1 enq_rdy", int'(enq_rdy), 1);
        take(1'b0, 0, 1'b0, "R1 empty no grant");

        // table walk: fill 8 slots, banks closed, R4/R5 ordering
        for (int i = 0; i < 8; i++)
            enq(FILL_WP[i][3], FILL_WP[i][2:0], 3'(i), 13'd0);
        #1;
        check(enq_rdy == 1'b0, "R2 full enq_rdy", int'(enq_rdy), 0);
        enq(1'b1, 3'd7, 3'd0, 13'd0); // dropped offer (R2)
        for (int i = 0; i < 8; i++)
            take(1'b1, EXP_ORD[i], FILL_WP[EXP_ORD[i]][3], "R4 table order");
        take(1'b0, 0, 1'b0, "R2 dropped offer absent");

        // R3 open-row hit preference and fallback
        enq(1'b0, 3'd7, 3'd1, 13'd5);  // slot0
        enq(1'b0, 3'd1, 3'd2, 13'd9);  // slot1
        bank_open = 8'b0000_0110;
        open_rows[1*13 +: 13] = 13'd6;
        open_rows[2*13 +: 13] = 13'd9;
        take(1'b1, 1, 1'b0, "R3 hit beats priority");
        take(1'b1, 0, 1'b0, "R3 fallback on miss");
        bank_open = '0;

        // R5 read over higher-priority write
        enq(1'b1, 3'd7, 3'd0, 13'd0);  // slot0 write
        enq(1'b0, 3'd0, 3'd0, 13'd0);  // slot1 read
        take(1'b1, 1, 1'b0, "R5 read first");
        enq(1'b0, 3'd0, 3'd0, 13'd0);  // slot1 read again
        rd_fifo_full = 1'b1;
        take(1'b1, 0, 1'b1, "R5 write when full");
        take(1'b0, 0, 1'b0, "R5 read blocked when full");
        rd_fifo_full = 1'b0;
        take(1'b1, 1, 1'b0, "R5 read after full clears");

        // R6 aging: threshold 2
        old_count = 8'd2;
        enq(1'b0, 3'd0, 3'd0, 13'd0);  // slot0 low prio
        enq(1'b0, 3'd7, 3'd0, 13'd0);  // slot1
        enq(1'b0, 3'd7, 3'd0, 13'd0);  // slot2
        enq(1'b0, 3'd7, 3'd0, 13'd0);  // slot3
        take(1'b1, 1, 1'b0, "R6 before aging");
        take(1'b1, 2, 1'b0, "R6 before aging 2");
        take(1'b1, 0, 1'b0, "R6 aged low prio wins");
        take(1'b1, 3, 1'b0, "R6 last");
        old_count = 8'hFE;

        // R8 grant and enqueue on the same edge
        enq(1'b0, 3'd3, 3'd0, 13'd0);  // slot0
        @(negedge clk);
        issue_rdy = 1'b1; enq_vld = 1'b1; enq_write = 1'b1; enq_prio = 3'd1;
        #1;
        check(grant_vld && grant_slot == 3'd0, "R8 grant with enqueue", int'(grant_slot), 0);
        @(negedge clk);
        issue_rdy = 1'b0; enq_vld = 1'b0;
        #1;
        check(grant_vld == 1'b0, "R7 no grant without ready", int'(grant_vld), 0);
        check(enq_rdy == 1'b1, "R9 not full", int'(enq_rdy), 1);
        old_count = 8'd1;
        enq(1'b1, 3'd7, 3'd0, 13'd0);  // slot0, newcomer in slot1 must not be aged
        take(1'b1, 0, 1'b1, "R8 wait count cleared");
        take(1'b1, 1, 1'b1, "R8 newcomer in slot1");
        take(1'b0, 0, 1'b0, "R9 empty again");
        old_count = 8'hFE;

        finish_run();
    end
endmodule